// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two independent 16-bit timer/counters, each kept as a low byte and a high byte. One shared configuration byte selects the counting mode for each timer and whether it counts prescaled clock ticks or falling edges on an external count pin. It also selects whether an external gate pin qualifies counting. A shared control byte holds the two sticky overflow flags and picks the prescale ratio. The prescale is either one tick every 12 clocks or, with the fast setting, one tick every 4 clocks.

Software reaches every register through a byte-wide write strobe, a 3-bit address and a combinational read path. Run enables come in on dedicated pins. Each timer reports its overflows two ways: as a sticky flag, and as a single-cycle tick. The timer 1 tick is also provided as a baud clock for a serial port.

Top module: `dual_timer_counter`

## Requirements
- R1: Under synchronous active-low reset all counters, the configuration byte, the control byte, both flags and both ticks are zero.
- R2: Register addresses are: 0 low byte of timer 0, 1 high byte of timer 0, 2 low byte of timer 1, 3 high byte of timer 1, 4 configuration, 5 control. Each register reads back what was written. In the control byte, bit 0 is the timer 0 flag, bit 1 is the timer 1 flag and bit 4 is the fast prescale; the other bits read 0. In the configuration byte, bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble, bit 3 is the gate enable, bit 2 selects counter mode (1) over timer mode (0), and bits [1:0] are the mode: 0 13-bit, 1 16-bit, 2 8-bit auto-reload, 3 split.
- R3: In timer mode an enabled timer advances exactly once per 12 clocks, or once per 4 clocks when fast prescale is set.
- R4: In counter mode the count pin is sampled every clock. The timer advances once per falling transition between two consecutive samples, and a steady level never advances it.
- R5: With the gate bit clear, the run pin alone enables counting. With the gate bit set, counting needs both the run pin and a high gate pin. A disabled timer holds its value.
- R6: In 16-bit mode the timer wraps from FFFF to 0000 and sets its overflow flag.
- R7: In 13-bit mode, low byte bits [4:0] form a 5-bit prescaler below the 8-bit high byte. Overflow happens when the high byte is FF and the low 5 bits are 1F. Low byte bits [7:5] never change.
- R8: In 8-bit auto-reload mode only the low byte counts. When it overflows from FF it loads the high byte, which itself stays unchanged, and the flag is set.
- R9: With timer 0 in split mode, timer 0's low byte counts under timer 0's own controls. Timer 0's high byte counts prescaled ticks while timer 1's run pin is high, and its overflow sets the timer 1 flag. A timer 1 set to split mode holds.
- R10: The overflow flags are sticky. Writing the control byte loads them, so writing 0 clears them.
- R11: A write to either byte of a timer suppresses that timer's increment in the same cycle; the written value wins.
- R12: Each overflow of a timer's main count gives a one-cycle pulse on its tick output. The baud tick equals the timer 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| run_en | input | 2 | Per-timer run enable |
| gate_pin | input | 2 | Per-timer external gate |
| count_pin | input | 2 | Per-timer external count input |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_tick | output | 2 | One-cycle overflow pulses |
| baud_tick | output | 1 | Timer 1 overflow pulse for a serial baud generator |

## Verification
The bench targets the wrap points where a carry is easy to get wrong:
- In 13-bit mode, a design that lets the carry touch low byte bits [7:5] shows a corrupted low byte.
- In auto-reload mode, a design that reloads from the wrong byte, or also counts the high byte, reads back a wrong value.
- In split mode, a design that wires timer 0's high byte to the wrong run pin or flag leaves timer 1's flag clear.

Other checks cover behaviour that only shows up over time:
- Counter mode is run with long steady levels; a design still counting prescale ticks there drifts high.
- The gate pin is held low with run high; a design that ignores the gate keeps counting.
- A byte write lands on a cycle that carries a tick; a design that lets the increment win misreports the low byte.
- Tick pulses are counted; a pulse stretched past one cycle is caught.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and register addresses of the dual timer/counter.
// Assumes an 8-bit register port with a 3-bit address.
package dtc_pkg;
    typedef enum logic [1:0] {
        MODE_13    = 2'd0,
        MODE_16    = 2'd1,
        MODE_8R    = 2'd2,
        MODE_SPLIT = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ctr;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam logic [2:0] ADDR_CFG  = 3'd4;
    localparam logic [2:0] ADDR_CTRL = 3'd5;
endpackage

// File: rtl/dtc_prescaler.sv
`timescale 1ns/1ps
// Prescaler: emits a one-cycle tick every SLOW_DIV clocks, or every
// FAST_DIV clocks while fast is high. Assumes FAST_DIV <= SLOW_DIV.
// Switching ratio resynchronises within one cycle.
module dtc_prescaler #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_w;

    // Select the terminal count for the active ratio.
    always_comb lim_w = fast ? FAST_LIM : SLOW_LIM;

    assign tick = (cnt_q >= lim_w);

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dtc_edge_sense.sv
`timescale 1ns/1ps
// Edge sense: samples each count pin every clock into two stages and
// flags a falling transition between consecutive samples.
// Assumes the pins are synchronous or already synchronised upstream.
module dtc_edge_sense #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] s0_q;
    logic [N-1:0] s1_q;

    // Two consecutive samples of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            s0_q <= pin;
            s1_q <= s0_q;
        end
    end

    // Falling transition: previous sample high, newest sample low.
    always_comb fall = s1_q & ~s0_q;
endmodule

// File: rtl/dtc_timer_core.sv
`timescale 1ns/1ps
// Timer core: one 16-bit timer kept as two bytes, with the 13-bit,
// 16-bit, 8-bit auto-reload and (if SPLIT_OK) split counting modes.
// Assumes inc_lo / inc_hi are already qualified by run, gate and event.
// Any byte write blocks both increments for that cycle.
module dtc_timer_core
    import dtc_pkg::*;
#(
    parameter int  W        = 8,
    parameter int  PRE_BITS = 5,
    parameter bit  SPLIT_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         inc_lo,
    input  logic         inc_hi,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tl,
    output logic [W-1:0] th,
    output logic         ovf_main,
    output logic         ovf_hi
);
    localparam logic [PRE_BITS-1:0] PRE_MAX = '1;
    localparam logic [W-1:0]        BYTE_MAX = '1;

    logic [W-1:0] tl_n;
    logic [W-1:0] th_n;

    // Next-state and overflow decode for the selected mode.
    always_comb begin
        tl_n     = tl;
        th_n     = th;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) tl_n = wdata;
            if (wr_hi) th_n = wdata;
        end else begin
            case (mode)
                MODE_13: if (inc_lo) begin
                    if (tl[PRE_BITS-1:0] == PRE_MAX) begin
                        tl_n[PRE_BITS-1:0] = '0;
                        th_n               = th + 1'b1;
                        ovf_main           = (th == BYTE_MAX);
                    end else begin
                        tl_n[PRE_BITS-1:0] = tl[PRE_BITS-1:0] + 1'b1;
                    end
                end
                MODE_16: if (inc_lo) begin
                    {th_n, tl_n} = {th, tl} + 1'b1;
                    ovf_main     = (th == BYTE_MAX) && (tl == BYTE_MAX);
                end
                MODE_8R: if (inc_lo) begin
                    if (tl == BYTE_MAX) begin
                        tl_n     = th;
                        ovf_main = 1'b1;
                    end else begin
                        tl_n = tl + 1'b1;
                    end
                end
                MODE_SPLIT: if (SPLIT_OK) begin
                    if (inc_lo) begin
                        tl_n     = tl + 1'b1;
                        ovf_main = (tl == BYTE_MAX);
                    end
                    if (inc_hi) begin
                        th_n   = th + 1'b1;
                        ovf_hi = (th == BYTE_MAX);
                    end
                end
                default: ;
            endcase
        end
    end

    // Byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl <= '0;
            th <= '0;
        end else begin
            tl <= tl_n;
            th <= th_n;
        end
    end
endmodule

// File: rtl/dual_timer_counter.sv
`timescale 1ns/1ps
// Dual timer/counter top: register file, enable qualification, flag
// and tick generation around two timer cores. Timer 0 supports split
// mode; timer 1 holds in that mode. Assumes synchronous inputs.
module dual_timer_counter
    import dtc_pkg::*;
#(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4,
    parameter int NT       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [NT-1:0] run_en,
    input  logic [NT-1:0] gate_pin,
    input  logic [NT-1:0] count_pin,
    output logic [NT-1:0] ovf_flag,
    output logic [NT-1:0] ovf_tick,
    output logic          baud_tick
);
    localparam int CFG_W = 4;

    logic [NT-1:0][7:0] tl_w;
    logic [NT-1:0][7:0] th_w;
    logic [7:0]         mode_q;
    logic               fast_q;
    logic [NT-1:0]      flag_q;
    logic [NT-1:0]      tick_q;
    logic               presc_tick;
    logic [NT-1:0]      fall_w;
    logic [NT-1:0]      ovf_main_w;
    logic [NT-1:0]      ovf_hi_w;
    logic [NT-1:0]      flag_set_w;
    logic               split0_w;
    logic               wr_cfg_w;
    logic               wr_ctrl_w;

    dtc_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fast  (fast_q),
        .tick  (presc_tick)
    );

    dtc_edge_sense #(.N(NT)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (count_pin),
        .fall  (fall_w)
    );

    assign wr_cfg_w  = reg_wr && (reg_addr == ADDR_CFG);
    assign wr_ctrl_w = reg_wr && (reg_addr == ADDR_CTRL);

    genvar gi;
    generate
        for (gi = 0; gi < NT; gi++) begin : g_tmr
            tmr_cfg_t cfg_w;
            logic     en_w;
            logic     event_w;
            logic     inc_hi_w;

            // Unpack this timer's configuration nibble.
            assign cfg_w    = mode_q[CFG_W*gi +: CFG_W];
            // Run pin, optionally qualified by the gate pin.
            assign en_w     = run_en[gi] && (!cfg_w.gate || gate_pin[gi]);
            // Counting event: pin edge in counter mode, prescale tick otherwise.
            assign event_w  = cfg_w.ctr ? fall_w[gi] : presc_tick;
            // Split high byte of timer 0 runs on timer 1's run pin.
            if (gi == 0) begin : g_hi
                assign inc_hi_w = presc_tick && run_en[NT-1];
            end else begin : g_nohi
                assign inc_hi_w = 1'b0;
            end

            dtc_timer_core #(.W(8), .PRE_BITS(5), .SPLIT_OK(gi == 0)) core_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (cfg_w.mode),
                .inc_lo   (en_w && event_w),
                .inc_hi   (inc_hi_w),
                .wr_lo    (reg_wr && (reg_addr == 3'(2*gi))),
                .wr_hi    (reg_wr && (reg_addr == 3'(2*gi + 1))),
                .wdata    (reg_wdata),
                .tl       (tl_w[gi]),
                .th       (th_w[gi]),
                .ovf_main (ovf_main_w[gi]),
                .ovf_hi   (ovf_hi_w[gi])
            );
        end
    endgenerate

    assign split0_w = (mode_q[1:0] == MODE_SPLIT);

    // Flag set sources: timer 1's flag is taken over by the split high byte.
    always_comb begin
        flag_set_w    = ovf_main_w;
        flag_set_w[1] = (split0_w ? ovf_hi_w[0] : ovf_main_w[1]) | ovf_hi_w[1];
    end

    // Configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= '0;
        else if (wr_cfg_w) mode_q <= reg_wdata;
    end

    // Control byte: fast prescale and sticky flags; a write wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            flag_q <= '0;
        end else if (wr_ctrl_w) begin
            fast_q <= reg_wdata[4];
            flag_q <= reg_wdata[NT-1:0];
        end else begin
            flag_q <= flag_q | flag_set_w;
        end
    end

    // One-cycle overflow ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= ovf_main_w;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            3'd0:      reg_rdata = tl_w[0];
            3'd1:      reg_rdata = th_w[0];
            3'd2:      reg_rdata = tl_w[1];
            3'd3:      reg_rdata = th_w[1];
            ADDR_CFG:  reg_rdata = mode_q;
            ADDR_CTRL: reg_rdata = {3'b000, fast_q, 2'b00, flag_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign ovf_flag  = flag_q;
    assign ovf_tick  = tick_q;
    assign baud_tick = tick_q[1];
endmodule

// File: rtl/dtc_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the dual timer/counter, bound to the top.
module dtc_checker (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [2:0]      reg_addr,
    input logic [7:0]      reg_wdata,
    input logic [1:0]      run_en,
    input logic [1:0]      ovf_flag,
    input logic [1:0]      ovf_tick,
    input logic [1:0][7:0] tl_w,
    input logic [1:0][7:0] th_w,
    input logic [1:0]      t0_mode,
    input logic [1:0]      t1_mode
);
    // R1: reset clears state.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ovf_flag == 2'b00 && ovf_tick == 2'b00 && tl_w == '0 && th_w == '0));

    // R11: a low-byte write lands regardless of any increment.
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> (tl_w[0] == $past(reg_wdata)));

    // R10: flags stay set until the control byte is written.
    assert_flag0_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag[0] && !(reg_wr && reg_addr == 3'd5)) |=> ovf_flag[0]);
    assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag[1] && !(reg_wr && reg_addr == 3'd5)) |=> ovf_flag[1]);

    // R12: ticks are single-cycle pulses.
    assert_tick0_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick[0] |=> !ovf_tick[0]);
    assert_tick1_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick[1] |=> !ovf_tick[1]);

    // R5: a timer without run and without writes holds.
    assert_hold0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en[0] && t0_mode != 2'd3 && !(reg_wr && reg_addr <= 3'd1))
        |=> ($stable(tl_w[0]) && $stable(th_w[0])));
    assert_hold1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en[1] && t1_mode != 2'd3 && !(reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)))
        |=> ($stable(tl_w[1]) && $stable(th_w[1])));
endmodule

bind dual_timer_counter dtc_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .run_en    (run_en),
    .ovf_flag  (ovf_flag),
    .ovf_tick  (ovf_tick),
    .tl_w      (tl_w),
    .th_w      (th_w),
    .t0_mode   (mode_q[1:0]),
    .t1_mode   (mode_q[5:4])
);

// File: tb/dual_timer_counter_tb_top.sv
`timescale 1ns/1ps
module dual_timer_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] run_en = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] count_pin = 2'b00;
    logic [1:0] ovf_flag;
    logic [1:0] ovf_tick;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    int tick0_cnt = 0;
    int tick1_cnt = 0;
    int baud_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_timer_counter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .run_en    (run_en),
        .gate_pin  (gate_pin),
        .count_pin (count_pin),
        .ovf_flag  (ovf_flag),
        .ovf_tick  (ovf_tick),
        .baud_tick (baud_tick)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (ovf_tick[0]) tick0_cnt++;
        if (ovf_tick[1]) tick1_cnt++;
        if (baud_tick)   baud_cnt++;
    end

    // Vector: mode(8) fast(1) preload(16) cycles(16) expected(16) flag0(1).
    localparam int NV = 8;
    localparam logic [57:0] VEC [NV] = '{
        {8'h01, 1'b0, 16'h0000, 16'd120, 16'h000A, 1'b0},
        {8'h01, 1'b1, 16'h0000, 16'd40,  16'h000A, 1'b0},
        {8'h01, 1'b1, 16'hFFFE, 16'd12,  16'h0001, 1'b1},
        {8'h01, 1'b0, 16'h00FF, 16'd12,  16'h0100, 1'b0},
        {8'h00, 1'b1, 16'hFFE0, 16'd128, 16'h00E0, 1'b1},
        {8'h00, 1'b1, 16'h0000, 16'd132, 16'h0101, 1'b0},
        {8'h02, 1'b1, 16'hF0FE, 16'd12,  16'hF0F1, 1'b1},
        {8'h02, 1'b0, 16'h8080, 16'd36,  16'h8083, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(input int t, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'(2*t), lo);
        rd(3'(2*t + 1), hi);
        v = {hi, lo};
    endtask

    task automatic run_for(input logic [1:0] r, input int n);
        @(negedge clk);
        run_en = r;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run_en = 2'b00;
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int          t0, t1, bd;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk("R1 register after reset", {8'h00, b}, 16'h0000);
        end
        chk("R1 flags/ticks after reset", {12'h000, ovf_flag, ovf_tick}, 16'h0000);

        // R2 register map and readback
        wr(3'd4, 8'hA5); rd(3'd4, b); chk("R2 config readback", {8'h00, b}, 16'h00A5);
        wr(3'd5, 8'hFF); rd(3'd5, b); chk("R2 control readback", {8'h00, b}, 16'h0013);
        wr(3'd2, 8'h3C); rd(3'd2, b); chk("R2 timer1 low readback", {8'h00, b}, 16'h003C);
        wr(3'd4, 8'h00);

        // Vector table: R3 prescale, R6 16-bit wrap, R7 13-bit, R8 auto-reload
        for (int i = 0; i < NV; i++) begin
            logic [57:0] vv;
            vv = VEC[i];
            wr(3'd5, vv[49] ? 8'h10 : 8'h00);
            wr(3'd4, vv[57:50]);
            wr(3'd0, vv[40:33]);
            wr(3'd1, vv[48:41]);
            run_for(2'b01, int'(vv[32:17]));
            repeat (2) @(negedge clk);
            rd16(0, v);
            chk($sformatf("vector %0d count (R3 R6 R7 R8)", i), v, vv[16:1]);
            chk($sformatf("vector %0d flag0 (R6 R7 R8)", i), {15'h0, ovf_flag[0]}, {15'h0, vv[0]});
        end

        // R4 counter mode on falling edges of the count pin
        wr(3'd5, 8'h10); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        @(negedge clk); run_en = 2'b01;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); count_pin[0] = 1'b1;
            repeat (3) @(negedge clk);
            count_pin[0] = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd16(0, v); chk("R4 five falling edges", v, 16'h0005);
        repeat (40) @(negedge clk);
        rd16(0, v); chk("R4 steady low level does not count", v, 16'h0005);
        @(negedge clk); run_en = 2'b00;

        // R5 gate qualification
        wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        @(negedge clk); gate_pin = 2'b00;
        run_for(2'b01, 40);
        rd16(0, v); chk("R5 gate low blocks counting", v, 16'h0000);
        @(negedge clk); gate_pin = 2'b01;
        run_for(2'b01, 40);
        rd16(0, v); chk("R5 gate high with run counts", v, 16'h000A);
        repeat (40) @(negedge clk);
        rd16(0, v); chk("R5 run low holds", v, 16'h000A);
        wr(3'd4, 8'h01);
        @(negedge clk); gate_pin = 2'b00;
        run_for(2'b01, 40);
        rd16(0, v); chk("R5 gate bit clear ignores gate pin", v, 16'h0014);

        // R9 split mode of timer 0
        wr(3'd5, 8'h10); wr(3'd4, 8'h33);
        wr(3'd0, 8'h20); wr(3'd1, 8'hFE); wr(3'd2, 8'h05); wr(3'd3, 8'h00);
        run_for(2'b10, 8);
        repeat (2) @(negedge clk);
        rd16(0, v); chk("R9 split high byte counts on run1", v, 16'h0020);
        rd16(1, v); chk("R9 timer1 in split mode holds", v, 16'h0005);
        chk("R9 split high overflow sets flag1 only", {14'h0, ovf_flag}, 16'h0002);
        run_for(2'b01, 8);
        rd16(0, v); chk("R9 split low byte counts on run0", v, 16'h0022);

        // R10 sticky flag and clear by write
        repeat (20) @(negedge clk);
        chk("R10 flag stays set", {14'h0, ovf_flag}, 16'h0002);
        wr(3'd5, 8'h10);
        chk("R10 write zero clears flags", {14'h0, ovf_flag}, 16'h0000);

        // R11 byte write suppresses the same-cycle increment
        wr(3'd4, 8'h01); wr(3'd0, 8'h10); wr(3'd1, 8'h00);
        @(negedge clk);
        run_en = 2'b01; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h44;
        repeat (8) @(posedge clk);
        @(negedge clk);
        run_en = 2'b00; reg_wr = 1'b0;
        rd16(0, v); chk("R11 write blocks increment", v, 16'h4410);

        // R12 overflow tick and baud tick from timer 1
        wr(3'd5, 8'h10); wr(3'd4, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        t0 = tick0_cnt; t1 = tick1_cnt; bd = baud_cnt;
        run_for(2'b10, 4);
        repeat (3) @(negedge clk);
        chk("R12 timer1 tick is one cycle", 16'(tick1_cnt - t1), 16'd1);
        chk("R12 baud tick follows timer1", 16'(baud_cnt - bd), 16'd1);
        chk("R12 timer0 tick idle", 16'(tick0_cnt - t0), 16'd0);
        rd16(1, v); chk("R6 timer1 wraps to zero", v, 16'h0000);
        chk("R6 timer1 flag set", {14'h0, ovf_flag}, 16'h0002);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd4, b); chk("R1 config cleared by reset", {8'h00, b}, 16'h0000);
        rd(3'd5, b); chk("R1 control cleared by reset", {8'h00, b}, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule